// File: doc/BRIEF.md
# Streaming Test Pattern Generator and Checker

This block feeds a storage engine that moves data as fixed-size files. In write mode it fills a 128-bit write FIFO with a known test pattern. In check mode it compares every word drained from a read FIFO against the same pattern, rebuilt on the fly. The pattern stays the same from run to run, so a file written in one run can be checked in a later run.

Each run is configured by a start pulse. The pulse latches the first file index, the file count, a 3-bit file-size code and a 3-bit pattern selector. The size code `c` gives a file of `2^c` blocks of 512 bytes, which is `32 << c` beats of 16 bytes. Three patterns (increment, decrement and LFSR) put a 64-bit block-address header at the head of every 512-byte block, so each block can be told apart. A running byte count is always visible. The first mismatch seen while checking freezes a record of where it happened and what was seen.

The write side stops by itself after the requested number of files. The read side has no length: it takes a word whenever the read FIFO holds one. A run should be either a write run or a check run, because both sides share one pattern generator.

Top module: `stream_patgen`

## Requirements
- R1: After reset, `wff_wren`, `wr_busy`, `fail` and `byte_count` are all 0.
- R2: A `start` pulse latches the configuration inputs, clears `byte_count`, clears `fail`, and restarts the pattern at beat 0. From the next cycle, `wr_busy` is 1 only if `start_write` was 1 and `file_count` was not 0.
- R3: `wff_wren` is 1 exactly when `wr_busy` is 1 and `wff_afull` is 0. While `wff_afull` is high, no word is written.
- R4: A write run writes exactly `file_count * (32 << size_code)` words. After the last one, `wr_busy` and `wff_wren` drop to 0.
- R5: For pattern codes 000, 001 and 100, the first beat of each 32-beat block carries a 64-bit header: lane 0 (bits 31:0) holds the low half and lane 1 holds the high half. The header starts at `file_first << size_code` and rises by 1 per block.
- R6: On beat k (counted from 0 since start), lane i (bits 32i+31:32i) is `4k+i` mod 2^32 for code 000 (increment), or the bitwise inverse of that for code 001 (decrement). Header lanes override lanes 0 and 1 on block-head beats.
- R7: Code 010 gives all-zero words and code 011 gives all-one words. Neither has a header. Codes 101 to 111 also give all-zero words.
- R8: Code 100 uses the LFSR step `s' = {s[30:0], s[30]^s[20]^s[0]}` with a seed of 1 at start. Lane i of beat k is the seed after `4k+i` steps.
- R9: `rff_rden` equals the inverse of `rff_empty` at all times, whatever `wr_busy`, the start pulse or the file count. Each read advances the pattern by one beat.
- R10: On the first read word that differs from the expected word, `fail` rises one cycle later. The same update captures the expected word, the read word, the low 32 bits of the byte offset within the file (`(k mod (32<<c))*16`) and the 16-bit file index (`file_first + k/(32<<c)`). Later mismatches change none of these.
- R11: `byte_count` (41 bits) equals 16 times the number of words written or read since the last start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle run start; latches the configuration |
| start_write | input | 1 | 1 starts a write run, 0 a check run |
| file_first | input | 16 | Index of the first file |
| file_count | input | 16 | Number of files to write |
| size_code | input | 3 | File size: 2^code blocks of 512 bytes |
| patt_sel | input | 3 | Pattern code |
| wr_busy | output | 1 | Write run in progress |
| wff_afull | input | 1 | Write FIFO almost full |
| wff_wren | output | 1 | Write FIFO write enable |
| wff_wdata | output | 128 | Write FIFO data |
| rff_empty | input | 1 | Read FIFO empty |
| rff_rden | output | 1 | Read FIFO read enable |
| rff_rdata | input | 128 | Read FIFO data, valid while not empty |
| byte_count | output | 41 | Bytes moved since start |
| fail | output | 1 | Sticky first-mismatch flag |
| fail_exp | output | 128 | Expected word at first mismatch |
| fail_got | output | 128 | Read word at first mismatch |
| fail_offset | output | 32 | Byte offset in file of first mismatch |
| fail_file | output | 16 | File index of first mismatch |

## Verification
A beat counter that slips by one shows up on the very next written word. The lane values are off by four, or the header lands on the wrong beat, so every following word compares wrong. A wrong block-address register is visible on the next block-head beat, and a bad LFSR step is visible within one word. A wrong end count shows up as one beat too many or too few before `wr_busy` falls. Capture faults show up once the check run ends: the frozen offset or file index is wrong, or a second injected mismatch overwrites the first record.

// File: rtl/stream_patgen_pkg.sv
package stream_patgen_pkg;

   typedef enum logic [2:0] {
      PAT_INC  = 3'b000,
      PAT_DEC  = 3'b001,
      PAT_ZERO = 3'b010,
      PAT_ONE  = 3'b011,
      PAT_LFSR = 3'b100
   } pat_e;

   localparam int unsigned LFSR_W = 32;

   // one shift of the x^31 + x^21 + x + 1 register
   function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
      return {s[LFSR_W-2:0], s[30] ^ s[20] ^ s[0]};
   endfunction

   function automatic logic pat_has_header(input logic [2:0] p);
      return (p == PAT_INC) || (p == PAT_DEC) || (p == PAT_LFSR);
   endfunction

endpackage

// File: rtl/sp_lfsr_ahead.sv
module sp_lfsr_ahead
   import stream_patgen_pkg::*;
#(
   parameter int unsigned STEPS = 4,
   parameter logic [LFSR_W-1:0] SEED = 32'h1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic                     adv,
   output logic [STEPS*LFSR_W-1:0]  lanes
);
   logic [LFSR_W-1:0] state_q;
   logic [LFSR_W-1:0] chain [STEPS+1];

   assign chain[0] = state_q;
   for (genvar i = 0; i < STEPS; i++) begin : g_ahead
      assign chain[i+1] = lfsr_step(chain[i]);
      assign lanes[i*LFSR_W +: LFSR_W] = chain[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || load) state_q <= SEED;
      else if (adv)       state_q <= chain[STEPS];
   end
endmodule

// File: rtl/sp_word_build.sv
module sp_word_build
   import stream_patgen_pkg::*;
#(
   parameter int unsigned LANES = 4,
   localparam int unsigned DW   = LFSR_W
) (
   input  logic [2:0]          pat,
   input  logic                hdr_beat,
   input  logic [2*DW-1:0]     addr,
   input  logic [DW-1:0]       dcnt,
   input  logic [LANES*DW-1:0] lfsr_lanes,
   output logic [LANES*DW-1:0] word
);
   logic use_hdr;
   assign use_hdr = hdr_beat && pat_has_header(pat);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [DW-1:0] inc, body;
      assign inc = dcnt + DW'(i);
      always_comb begin
         case (pat)
            PAT_INC:  body = inc;
            PAT_DEC:  body = ~inc;
            PAT_ONE:  body = '1;
            PAT_LFSR: body = lfsr_lanes[i*DW +: DW];
            default:  body = '0;
         endcase
      end
      if (i < 2) begin : g_hdr
         assign word[i*DW +: DW] = use_hdr ? addr[i*DW +: DW] : body;
      end else begin : g_body
         assign word[i*DW +: DW] = body;
      end
   end
endmodule

// File: rtl/sp_fail_capture.sv
module sp_fail_capture #(
   parameter int unsigned DATA_W = 128,
   parameter int unsigned OFS_W  = 32,
   parameter int unsigned FN_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              chk,
   input  logic [DATA_W-1:0] exp_word,
   input  logic [DATA_W-1:0] got_word,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [FN_W-1:0]   fname,
   output logic              fail,
   output logic [DATA_W-1:0] cap_exp,
   output logic [DATA_W-1:0] cap_got,
   output logic [OFS_W-1:0]  cap_ofs,
   output logic [FN_W-1:0]   cap_fn
);
   logic first_bad;
   assign first_bad = chk && !fail && (exp_word != got_word);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         fail    <= 1'b0;
         cap_exp <= '0;
         cap_got <= '0;
         cap_ofs <= '0;
         cap_fn  <= '0;
      end else if (first_bad) begin
         fail    <= 1'b1;
         cap_exp <= exp_word;
         cap_got <= got_word;
         cap_ofs <= ofs;
         cap_fn  <= fname;
      end
   end
endmodule

// File: rtl/stream_patgen.sv
module stream_patgen
   import stream_patgen_pkg::*;
#(
   parameter int unsigned DATA_W    = 128,
   parameter int unsigned FN_W      = 16,
   parameter int unsigned CNT_W     = 41,
   parameter int unsigned OFS_W     = 32,
   parameter int unsigned SZ_W      = 3,
   parameter int unsigned BLK_BYTES = 512,
   parameter logic [31:0] SEED      = 32'h1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_write,
   input  logic [FN_W-1:0]   file_first,
   input  logic [FN_W-1:0]   file_count,
   input  logic [SZ_W-1:0]   size_code,
   input  logic [2:0]        patt_sel,
   output logic              wr_busy,
   input  logic              wff_afull,
   output logic              wff_wren,
   output logic [DATA_W-1:0] wff_wdata,
   input  logic              rff_empty,
   output logic              rff_rden,
   input  logic [DATA_W-1:0] rff_rdata,
   output logic [CNT_W-1:0]  byte_count,
   output logic              fail,
   output logic [DATA_W-1:0] fail_exp,
   output logic [DATA_W-1:0] fail_got,
   output logic [OFS_W-1:0]  fail_offset,
   output logic [FN_W-1:0]   fail_file
);
   localparam int unsigned DW         = LFSR_W;
   localparam int unsigned LANES      = DATA_W / DW;
   localparam int unsigned BYTE_LOG2  = $clog2(DATA_W / 8);
   localparam int unsigned BLK_LOG2   = $clog2(BLK_BYTES / (DATA_W / 8));
   localparam int unsigned BEAT_W     = CNT_W - BYTE_LOG2;
   localparam int unsigned ADDR_W     = 2 * DW;

   if (DATA_W != LANES * DW || LANES < 2) begin : g_bad_width
      $error("DATA_W must be a multiple of 32 with at least two lanes");
   end
   if ((1 << BLK_LOG2) * (DATA_W / 8) != BLK_BYTES) begin : g_bad_blk
      $error("BLK_BYTES must be a power-of-two number of beats");
   end
   if (BEAT_W < FN_W + BLK_LOG2 + (1 << SZ_W)) begin : g_bad_cnt
      $error("CNT_W too small for the largest run");
   end

   logic [FN_W-1:0]   cfg_ff, cfg_fc;
   logic [SZ_W-1:0]   cfg_code;
   logic [2:0]        cfg_pat;
   logic [BEAT_W-1:0] beat_cnt;
   logic [ADDR_W-1:0] addr_q;
   logic [DW-1:0]     dcnt;
   logic [DATA_W-1:0] lfsr_lanes, exp_word;
   logic [BEAT_W-1:0] end_beats, file_beats, in_file;
   logic [CNT_W-1:0]  ofs_full;
   logic              beat, last_beat;

   assign wff_wren   = wr_busy && !wff_afull;
   assign rff_rden   = !rff_empty;
   assign beat       = wff_wren || rff_rden;
   assign file_beats = BEAT_W'(1) << (BLK_LOG2 + cfg_code);
   assign end_beats  = BEAT_W'(cfg_fc) << (BLK_LOG2 + cfg_code);
   assign last_beat  = (beat_cnt + BEAT_W'(1)) == end_beats;
   assign in_file    = beat_cnt & (file_beats - BEAT_W'(1));
   assign ofs_full   = {in_file, {BYTE_LOG2{1'b0}}};
   assign byte_count = {beat_cnt, {BYTE_LOG2{1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_ff   <= '0;
         cfg_fc   <= '0;
         cfg_code <= '0;
         cfg_pat  <= '0;
         wr_busy  <= 1'b0;
         beat_cnt <= '0;
         addr_q   <= '0;
         dcnt     <= '0;
      end else if (start) begin
         cfg_ff   <= file_first;
         cfg_fc   <= file_count;
         cfg_code <= size_code;
         cfg_pat  <= patt_sel;
         wr_busy  <= start_write && (file_count != '0);
         beat_cnt <= '0;
         addr_q   <= ADDR_W'(file_first) << size_code;
         dcnt     <= '0;
      end else if (beat) begin
         beat_cnt <= beat_cnt + BEAT_W'(1);
         dcnt     <= dcnt + DW'(LANES);
         if (&beat_cnt[BLK_LOG2-1:0]) addr_q <= addr_q + ADDR_W'(1);
         if (wff_wren && last_beat)   wr_busy <= 1'b0;
      end
   end

   sp_lfsr_ahead #(.STEPS(LANES), .SEED(SEED)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .adv   (beat && !start),
      .lanes (lfsr_lanes)
   );

   sp_word_build #(.LANES(LANES)) u_word (
      .pat        (cfg_pat),
      .hdr_beat   (beat_cnt[BLK_LOG2-1:0] == '0),
      .addr       (addr_q),
      .dcnt       (dcnt),
      .lfsr_lanes (lfsr_lanes),
      .word       (exp_word)
   );

   assign wff_wdata = exp_word;

   sp_fail_capture #(.DATA_W(DATA_W), .OFS_W(OFS_W), .FN_W(FN_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start),
      .chk      (rff_rden && !start),
      .exp_word (exp_word),
      .got_word (rff_rdata),
      .ofs      (OFS_W'(ofs_full)),
      .fname    (cfg_ff + FN_W'(beat_cnt >> (BLK_LOG2 + cfg_code))),
      .fail     (fail),
      .cap_exp  (fail_exp),
      .cap_got  (fail_got),
      .cap_ofs  (fail_offset),
      .cap_fn   (fail_file)
   );
endmodule

// File: rtl/stream_patgen_chk.sv
module stream_patgen_chk #(
   parameter int unsigned DATA_W = 128,
   parameter int unsigned CNT_W  = 41
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              wr_busy,
   input logic              wff_afull,
   input logic              wff_wren,
   input logic              rff_rden,
   input logic              fail,
   input logic [CNT_W-1:0]  byte_count,
   input logic [DATA_W-1:0] fail_exp,
   input logic [DATA_W-1:0] fail_got
);
   AST_WREN_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      wff_wren |-> (!wff_afull && wr_busy)); // R3

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!fail && byte_count == '0)); // R2

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && (wff_wren || rff_rden)) |=> byte_count == $past(byte_count) + CNT_W'(DATA_W / 8)); // R11

   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !wff_wren && !rff_rden) |=> $stable(byte_count)); // R11

   AST_FAIL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && fail) |=> (fail && $stable(fail_exp) && $stable(fail_got))); // R10

   AST_BUSY_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !wr_busy) |=> !wr_busy); // R4
endmodule

bind stream_patgen stream_patgen_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .wr_busy    (wr_busy),
   .wff_afull  (wff_afull),
   .wff_wren   (wff_wren),
   .rff_rden   (rff_rden),
   .fail       (fail),
   .byte_count (byte_count),
   .fail_exp   (fail_exp),
   .fail_got   (fail_got)
);

// File: tb/stream_patgen_test.sv
module stream_patgen_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0, start_write = 1'b0;
   logic [15:0]  file_first = '0, file_count = '0;
   logic [2:0]   size_code = '0, patt_sel = '0;
   logic         wr_busy, wff_afull = 1'b0, wff_wren;
   logic [127:0] wff_wdata;
   logic         rff_empty = 1'b1, rff_rden;
   logic [127:0] rff_rdata = '0;
   logic [40:0]  byte_count;
   logic         fail;
   logic [127:0] fail_exp, fail_got;
   logic [31:0]  fail_offset;
   logic [15:0]  fail_file;

   int checks = 0, bad = 0, cycles = 0;
   bit done = 0;

   always #4 clk = ~clk;

   stream_patgen uut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_write(start_write),
      .file_first(file_first), .file_count(file_count), .size_code(size_code),
      .patt_sel(patt_sel), .wr_busy(wr_busy), .wff_afull(wff_afull),
      .wff_wren(wff_wren), .wff_wdata(wff_wdata), .rff_empty(rff_empty),
      .rff_rden(rff_rden), .rff_rdata(rff_rdata), .byte_count(byte_count),
      .fail(fail), .fail_exp(fail_exp), .fail_got(fail_got),
      .fail_offset(fail_offset), .fail_file(fail_file)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] m_step(input logic [31:0] s);
      logic fb;
      fb = s[30] ^ s[20] ^ s[0];
      return {s[30:0], fb};
   endfunction

   function automatic logic [127:0] model_word(input int unsigned k, input logic [15:0] ff,
                                               input logic [2:0] code, input logic [2:0] p,
                                               input logic [31:0] lf);
      logic [127:0] w;
      logic [31:0]  s, v;
      logic [63:0]  a;
      s = lf;
      for (int i = 0; i < 4; i++) begin
         v = 32'(4 * k + i);
         case (p)
            3'b000: w[32*i +: 32] = v;
            3'b001: w[32*i +: 32] = ~v;
            3'b011: w[32*i +: 32] = '1;
            3'b100: w[32*i +: 32] = s;
            default: w[32*i +: 32] = '0;
         endcase
         s = m_step(s);
      end
      a = (64'(ff) << code) + 64'(k / 32);
      if ((k % 32) == 0 && (p == 3'b000 || p == 3'b001 || p == 3'b100)) w[63:0] = a;
      return w;
   endfunction

   function automatic string pat_req(input int unsigned k, input logic [2:0] p);
      if ((k % 32) == 0 && (p == 3'b000 || p == 3'b001 || p == 3'b100)) return "R5";
      if (p == 3'b100) return "R8";
      if (p == 3'b000 || p == 3'b001) return "R6";
      return "R7";
   endfunction

   task automatic do_start(input bit wr, input logic [15:0] ff, input logic [15:0] fc,
                           input logic [2:0] code, input logic [2:0] p);
      @(negedge clk);
      start = 1; start_write = wr; file_first = ff; file_count = fc; size_code = code; patt_sel = p;
      @(negedge clk);
      start = 0;
      file_first = ~ff; file_count = '0; size_code = 3'd7; patt_sel = 3'd6; // latched values must be used
      #1;
      chk(byte_count == '0, "R2", 128'(byte_count), 0);
      chk(fail == 1'b0, "R2", 128'(fail), 0);
      chk(wr_busy == (wr && fc != 0), "R2", 128'(wr_busy), 128'(wr && fc != 0));
   endtask

   task automatic run_write(input logic [15:0] ff, input logic [15:0] fc,
                            input logic [2:0] code, input logic [2:0] p);
      int unsigned nb, k;
      logic [31:0] lf;
      nb = 32'(fc) << (5 + code);
      k = 0; lf = 32'h1;
      do_start(1'b1, ff, fc, code, p);
      while (k < nb) begin
         wff_afull = ($urandom % 4) == 0;
         #1;
         chk(wff_wren == !wff_afull, "R3", 128'(wff_wren), 128'(!wff_afull));
         if (wff_wren) begin
            chk(wff_wdata == model_word(k, ff, code, p, lf), pat_req(k, p),
                wff_wdata, model_word(k, ff, code, p, lf));
            k++;
            for (int j = 0; j < 4; j++) lf = m_step(lf);
         end
         @(negedge clk);
      end
      wff_afull = 0;
      #1;
      chk(wr_busy == 1'b0, "R4", 128'(wr_busy), 0);
      chk(wff_wren == 1'b0, "R4", 128'(wff_wren), 0);
      chk(byte_count == 41'(nb) * 41'd16, "R11", 128'(byte_count), 128'(nb) * 16);
   endtask

   task automatic run_read(input logic [15:0] ff, input logic [2:0] code, input logic [2:0] p,
                           input int unsigned nb, input int bad1, input int bad2);
      int unsigned k;
      logic [31:0]  lf;
      logic [127:0] w, e, e_bad, g_bad;
      bit prev_first;
      k = 0; lf = 32'h1; prev_first = 0; e_bad = '0; g_bad = '0;
      do_start(1'b0, ff, 16'd1, code, p);
      while (k < nb) begin
         if (prev_first) begin
            chk(fail == 1'b1, "R10", 128'(fail), 1);
            prev_first = 0;
         end
         if (($urandom % 3) == 0) begin
            rff_empty = 1;
            #1;
            chk(rff_rden == 1'b0, "R9", 128'(rff_rden), 0);
         end else begin
            e = model_word(k, ff, code, p, lf);
            w = e;
            if (int'(k) == bad1 || int'(k) == bad2) w = e ^ (128'h1 << (k % 128));
            if (int'(k) == bad1) begin
               e_bad = e; g_bad = w; prev_first = 1;
               chk(fail == 1'b0, "R10", 128'(fail), 0);
            end
            rff_empty = 0; rff_rdata = w;
            #1;
            chk(rff_rden == 1'b1, "R9", 128'(rff_rden), 1);
            k++;
            for (int j = 0; j < 4; j++) lf = m_step(lf);
         end
         @(negedge clk);
      end
      rff_empty = 1;
      @(negedge clk);
      #1;
      chk(byte_count == 41'(nb) * 41'd16, "R11", 128'(byte_count), 128'(nb) * 16);
      chk(wr_busy == 1'b0, "R9", 128'(wr_busy), 0);
      if (bad1 < 0) begin
         chk(fail == 1'b0, "R10", 128'(fail), 0);
      end else begin
         chk(fail == 1'b1, "R10", 128'(fail), 1);
         chk(fail_exp == e_bad, "R10", fail_exp, e_bad);
         chk(fail_got == g_bad, "R10", fail_got, g_bad);
         chk(fail_offset == 32'((bad1 % (32 << code)) * 16), "R10",
             128'(fail_offset), 128'((bad1 % (32 << code)) * 16));
         chk(fail_file == 16'(ff + 16'(bad1 / (32 << code))), "R10",
             128'(fail_file), 128'(16'(ff + 16'(bad1 / (32 << code)))));
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         bad++; checks++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      // R1
      chk(wff_wren == 0, "R1", 128'(wff_wren), 0);
      chk(wr_busy == 0, "R1", 128'(wr_busy), 0);
      chk(byte_count == 0, "R1", 128'(byte_count), 0);
      chk(fail == 0, "R1", 128'(fail), 0);
      chk(rff_rden == 0, "R9", 128'(rff_rden), 0);

      run_write(16'd3, 16'd2, 3'd0, 3'b000);
      run_write(16'd10, 16'd1, 3'd1, 3'b001);
      run_write(16'd0, 16'd2, 3'd0, 3'b010);
      run_write(16'd7, 16'd1, 3'd0, 3'b011);
      run_write(16'd5, 16'd3, 3'd1, 3'b100);
      run_write(16'hFFFF, 16'd1, 3'd2, 3'b000);
      run_write(16'd4, 16'd1, 3'd0, 3'b110);
      for (int r = 0; r < 3; r++)
         run_write(16'($urandom), 16'($urandom % 3 + 1), 3'($urandom % 2), 3'($urandom % 5));

      // R2: zero file count never writes
      do_start(1'b1, 16'd9, 16'd0, 3'd0, 3'b000);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); #1;
         chk(wff_wren == 0 && byte_count == 0, "R2", 128'(wff_wren), 0);
      end

      // R9: reads run past any end count and without a write flag
      run_read(16'd2, 3'd0, 3'b100, 80, 37, 50);
      run_read(16'd9, 3'd1, 3'b000, 70, -1, -1);
      run_read(16'd1, 3'd0, 3'b001, 40, 0, 5);
      run_read(16'd300, 3'd0, 3'b011, 90, 70, 71);

      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule